// File: doc/BRIEF.md
# Transport packet priority scheduler

The scheduler decides, once per output slot, which fixed-length transport packet goes out next to a downstream Ethernet framing stage. Elementary-stream packetizers hold a level ready flag while a complete packet waits in their buffers. Table and clock-reference generators give a one-cycle request strobe when their own interval timers fall due. Stream packets always win. Among the requesters, lower source numbers win. Pending table and clock-reference requests come next. When nothing is pending, a null packet fills the slot, up to a programmable number of nulls per window of slots. When that budget is used up, the slot stays empty.

A chosen packet streams out one byte per clock for 188 cycles with busy high. The block raises a read strobe to the serving source and takes that source's byte in the same cycle. The scheduler itself writes the sync byte and the packet identifier field. It also generates null packets internally. A one-hot flag vector marks the source in flight, so that continuity counting further down the chain can pick the right counter. The gap between slots is a build-time setting.

Top module: `ts_pkt_sched`

## Requirements
- R1: During reset and immediately after its release, busy, pkt_start, src_rd and pid_flag are all zero.
- R2: A packet occupies exactly PKT_BYTES (188) consecutive cycles with busy high and one byte per cycle. pkt_start is high only in the first of these cycles. Throughout the packet, src_rd carries the one-hot bit of the source being served and zero for a null packet.
- R3: In a source packet, byte 0 is 0x47. Byte 1 keeps bits 7:5 of the source's byte 1 and replaces bits 4:0 with PID bits 12:8. Byte 2 is PID bits 7:0. Every other byte k is the byte the source presents on its k-th read cycle. The PID comes from the source's entry in SRC_PID.
- R4: At a slot decision, any asserted src_ready wins over all other requests. Among stream sources, the lowest index wins.
- R5: A tbl_req strobe is latched and held until its source is served, which happens exactly once however many strobes arrived meanwhile. A strobe that arrives during a packet is kept. Table sources are served only when no stream source is ready, with the lowest index first.
- R6: When no source is pending and null budget remains, a null packet is sent. Its bytes are 0x47, 0x1F, 0xFF, 0x10, and then 0xFF for the rest of the packet, which is PID 0x1FFF.
- R7: Each slot decision counts as one slot, whether it sends a source packet, a null packet or nothing. At most null_cap null packets are sent in each window of WINDOW_SLOTS slots, and the null count restarts at every window boundary. With null_cap equal to zero, no null packet is ever sent.
- R8: A slot decision is made after SLOT_GAP+1 idle cycles. Consecutive packets therefore start exactly PKT_BYTES+SLOT_GAP+1 cycles apart, and an empty slot lasts SLOT_GAP+1 cycles.
- R9: Once started, a packet always completes, and pid_flag stays constant for its whole length. A request that arrives during a packet waits for the next slot.
- R10: pid_flag is one-hot while busy and zero while idle. Bit s, for s below NUM_ES+NUM_TBL, marks source s: stream sources occupy the low indices and table source j sits at NUM_ES+j. The top bit marks a null packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_ready | input | NUM_ES | Level flags, one per stream source, high while a full packet waits |
| tbl_req | input | NUM_TBL | One-cycle request strobes from table and clock-reference generators |
| src_byte | input | 8*(NUM_ES+NUM_TBL) | Current byte of each source, 8 bits per source, source 0 lowest |
| null_cap | input | CAP_W | Null packets allowed per window of slots |
| src_rd | output | NUM_ES+NUM_TBL | One-hot read strobe to the source being served |
| pkt_byte | output | 8 | Outgoing packet byte |
| pkt_start | output | 1 | Trigger, high with the first byte of a packet |
| busy | output | 1 | High while a packet is being sent |
| pid_flag | output | NUM_ES+NUM_TBL+1 | One-hot source-in-flight vector, with the top bit for null |

## Verification
The bench builds the block with SLOT_GAP of 2 and a window of 4 slots. With these values, back-to-back starts fall exactly 191 cycles apart and each empty slot lasts 3 cycles. A null cap of 1 or 2 then shows up as a fixed rhythm of start-to-start intervals, 200 cycles in the first case and alternating 191 and 197 in the second, within a few windows. Two stream sources and four table sources are enough to set stream against stream, stream against table and table against table in the same slot. The bench also measures the handover interval when a stream request arrives in the middle of a null packet.

// File: rtl/ts_sched_pkg.sv
package ts_sched_pkg;

  localparam logic [7:0]  SYNC_BYTE = 8'h47;
  localparam logic [12:0] NULL_PID  = 13'h1FFF;
  localparam logic [7:0]  NULL_FLAGS = 8'h10;   // payload only, counter zero
  localparam logic [7:0]  FILL_BYTE = 8'hFF;

  // Byte idx of an internally generated null packet.
  function automatic logic [7:0] null_pkt_byte(input int unsigned idx);
    case (idx)
      0:       return SYNC_BYTE;
      1:       return {3'b000, NULL_PID[12:8]};
      2:       return NULL_PID[7:0];
      3:       return NULL_FLAGS;
      default: return FILL_BYTE;
    endcase
  endfunction

  // Byte idx of a source packet with sync and PID fields overwritten.
  function automatic logic [7:0] stamp_byte(input int unsigned idx,
                                            input logic [7:0] raw,
                                            input logic [12:0] pid);
    case (idx)
      0:       return SYNC_BYTE;
      1:       return {raw[7:5], pid[12:8]};
      2:       return pid[7:0];
      default: return raw;
    endcase
  endfunction

endpackage

// File: rtl/ts_slot_timer.sv
module ts_slot_timer #(
  parameter int SLOT_GAP     = 3,
  parameter int WINDOW_SLOTS = 8,
  parameter int CAP_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic             grant_null,
  input  logic [CAP_W-1:0] null_cap,
  output logic             slot_tick,
  output logic             null_ok,
  output logic [CAP_W-1:0] null_used
);
  localparam int GAP_W = $clog2(SLOT_GAP + 2);
  localparam int WIN_W = (WINDOW_SLOTS > 1) ? $clog2(WINDOW_SLOTS) : 1;

  logic [GAP_W-1:0] gap_cnt;
  logic [WIN_W-1:0] win_cnt;
  logic             win_last;

  assign slot_tick = idle && (gap_cnt == GAP_W'(SLOT_GAP));
  assign win_last  = (win_cnt == WIN_W'(WINDOW_SLOTS - 1));
  assign null_ok   = (null_used < null_cap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= '0;
    end else if (!idle || slot_tick) begin
      gap_cnt <= '0;
    end else begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt   <= '0;
      null_used <= '0;
    end else if (slot_tick) begin
      if (win_last) begin
        win_cnt   <= '0;
        null_used <= '0;
      end else begin
        win_cnt   <= win_cnt + 1'b1;
        null_used <= null_used + CAP_W'(grant_null);
      end
    end
  end

endmodule

// File: rtl/ts_src_arbiter.sv
module ts_src_arbiter #(
  parameter int NUM_ES  = 2,
  parameter int NUM_TBL = 4,
  localparam int NUM_SRC = NUM_ES + NUM_TBL
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ES-1:0]  es_ready,
  input  logic [NUM_TBL-1:0] tbl_req,
  input  logic               slot_tick,
  input  logic               null_ok,
  output logic [NUM_SRC:0]   grant,
  output logic [NUM_TBL-1:0] tbl_pend
);
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] pick;

  assign req  = {tbl_pend, es_ready};
  assign pick = req & (~req + 1'b1);   // lowest set bit wins

  assign grant[NUM_SRC-1:0] = slot_tick ? pick : '0;
  assign grant[NUM_SRC]     = slot_tick && (req == '0) && null_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_pend <= '0;
    end else begin
      tbl_pend <= (tbl_pend & ~grant[NUM_SRC-1:NUM_ES]) | tbl_req;
    end
  end

endmodule

// File: rtl/ts_pkt_engine.sv
module ts_pkt_engine
  import ts_sched_pkg::*;
#(
  parameter int NUM_SRC   = 6,
  parameter int PKT_BYTES = 188,
  parameter logic [NUM_SRC-1:0][12:0] SRC_PID = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC:0]     grant,
  input  logic [NUM_SRC*8-1:0] src_byte,
  output logic                 busy,
  output logic                 pkt_start,
  output logic [7:0]           pkt_byte,
  output logic [NUM_SRC:0]     pid_flag,
  output logic [NUM_SRC-1:0]   src_rd
);
  localparam int IDX_W = $clog2(PKT_BYTES);

  logic [IDX_W-1:0] idx;
  logic             last_byte;
  logic [NUM_SRC-1:0][7:0]  raw_m;
  logic [NUM_SRC-1:0][12:0] pid_m;
  logic [7:0]  raw_sel;
  logic [12:0] pid_sel;

  assign last_byte = busy && (idx == IDX_W'(PKT_BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      pid_flag <= '0;
    end else if (!busy) begin
      if (grant != '0) begin
        busy     <= 1'b1;
        idx      <= '0;
        pid_flag <= grant;
      end
    end else if (last_byte) begin
      busy     <= 1'b0;
      idx      <= '0;
      pid_flag <= '0;
    end else begin
      idx <= idx + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src_lane
    assign raw_m[g] = pid_flag[g] ? src_byte[g*8 +: 8] : 8'h00;
    assign pid_m[g] = pid_flag[g] ? SRC_PID[g] : 13'h0;
  end

  always_comb begin
    raw_sel = '0;
    pid_sel = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      raw_sel = raw_sel | raw_m[i];
      pid_sel = pid_sel | pid_m[i];
    end
  end

  always_comb begin
    if (!busy) begin
      pkt_byte = 8'h00;
    end else if (pid_flag[NUM_SRC]) begin
      pkt_byte = null_pkt_byte(32'(idx));
    end else begin
      pkt_byte = stamp_byte(32'(idx), raw_sel, pid_sel);
    end
  end

  assign pkt_start = busy && (idx == '0);
  assign src_rd    = pid_flag[NUM_SRC-1:0];

endmodule

// File: rtl/ts_pkt_sched.sv
module ts_pkt_sched #(
  parameter int NUM_ES       = 2,
  parameter int NUM_TBL      = 4,
  parameter int PKT_BYTES    = 188,
  parameter int SLOT_GAP     = 3,
  parameter int WINDOW_SLOTS = 8,
  parameter int CAP_W        = 4,
  parameter logic [NUM_ES+NUM_TBL-1:0][12:0] SRC_PID =
    {13'h1001, 13'h001F, 13'h1000, 13'h0000, 13'h0101, 13'h0100}
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_ES-1:0]             src_ready,
  input  logic [NUM_TBL-1:0]            tbl_req,
  input  logic [(NUM_ES+NUM_TBL)*8-1:0] src_byte,
  input  logic [CAP_W-1:0]              null_cap,
  output logic [NUM_ES+NUM_TBL-1:0]     src_rd,
  output logic [7:0]                    pkt_byte,
  output logic                          pkt_start,
  output logic                          busy,
  output logic [NUM_ES+NUM_TBL:0]       pid_flag
);
  localparam int NUM_SRC = NUM_ES + NUM_TBL;

  logic               slot_tick;
  logic               null_ok;
  logic [CAP_W-1:0]   null_used;
  logic [NUM_SRC:0]   grant;
  logic [NUM_TBL-1:0] tbl_pend;

  ts_slot_timer #(
    .SLOT_GAP(SLOT_GAP), .WINDOW_SLOTS(WINDOW_SLOTS), .CAP_W(CAP_W)
  ) i_timer (
    .clk(clk), .rst_n(rst_n), .idle(!busy), .grant_null(grant[NUM_SRC]),
    .null_cap(null_cap), .slot_tick(slot_tick), .null_ok(null_ok),
    .null_used(null_used)
  );

  ts_src_arbiter #(.NUM_ES(NUM_ES), .NUM_TBL(NUM_TBL)) i_arb (
    .clk(clk), .rst_n(rst_n), .es_ready(src_ready), .tbl_req(tbl_req),
    .slot_tick(slot_tick), .null_ok(null_ok), .grant(grant),
    .tbl_pend(tbl_pend)
  );

  ts_pkt_engine #(
    .NUM_SRC(NUM_SRC), .PKT_BYTES(PKT_BYTES), .SRC_PID(SRC_PID)
  ) i_eng (
    .clk(clk), .rst_n(rst_n), .grant(grant), .src_byte(src_byte),
    .busy(busy), .pkt_start(pkt_start), .pkt_byte(pkt_byte),
    .pid_flag(pid_flag), .src_rd(src_rd)
  );

endmodule

// File: rtl/ts_pkt_sched_chk.sv
module ts_pkt_sched_chk #(
  parameter int NUM_ES    = 2,
  parameter int NUM_TBL   = 4,
  parameter int PKT_BYTES = 188,
  parameter int CAP_W     = 4,
  localparam int NUM_SRC  = NUM_ES + NUM_TBL
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               pkt_start,
  input logic [7:0]         pkt_byte,
  input logic [NUM_SRC:0]   pid_flag,
  input logic [NUM_SRC-1:0] src_rd,
  input logic [NUM_ES-1:0]  src_ready,
  input logic [NUM_TBL-1:0] tbl_pend,
  input logic [CAP_W-1:0]   null_used,
  input logic [CAP_W-1:0]   null_cap
);
  localparam int RUN_W = $clog2(PKT_BYTES + 1);
  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) run_len <= '0;
    else                 run_len <= run_len + 1'b1;
  end

  // R1: quiet outputs while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!busy && !pkt_start && src_rd == '0 && pid_flag == '0);
    end
  end

  assert_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |-> ($past(run_len) == RUN_W'(PKT_BYTES - 1)));

  assert_start_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> pkt_start);

  assert_rd_inside_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_rd) && ((src_rd != '0) -> busy));

  assert_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> (busy && pkt_byte == 8'h47));

  assert_es_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_start && pid_flag[NUM_SRC:NUM_ES] != '0) |-> ($past(src_ready) == '0));

  assert_null_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_start && pid_flag[NUM_SRC]) |-> ($past(tbl_pend) == '0 && $past(src_ready) == '0));

  assert_null_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_start && pid_flag[NUM_SRC]) |-> ($past(null_used) < $past(null_cap)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pid_flag));

  assert_flag_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pid_flag) && (busy == (pid_flag != '0)));

endmodule

bind ts_pkt_sched ts_pkt_sched_chk #(
  .NUM_ES(NUM_ES), .NUM_TBL(NUM_TBL), .PKT_BYTES(PKT_BYTES), .CAP_W(CAP_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .pkt_start(pkt_start),
  .pkt_byte(pkt_byte), .pid_flag(pid_flag), .src_rd(src_rd),
  .src_ready(src_ready), .tbl_pend(tbl_pend), .null_used(null_used),
  .null_cap(null_cap)
);

// File: tb/test_ts_pkt_sched.sv
`timescale 1ns/1ps
module test_ts_pkt_sched;
  localparam int NES = 2;
  localparam int NTB = 4;
  localparam int NS  = NES + NTB;
  localparam int PKT = 188;
  localparam int G   = 2;
  localparam int W   = 4;
  localparam int CW  = 3;
  localparam int S_DELTA = PKT + G + 1;
  localparam logic [NS-1:0][12:0] PIDS =
    {13'h1001, 13'h001F, 13'h1000, 13'h0000, 13'h0101, 13'h0100};

  // {es[1:0], tbl[3:0], expected first flag[6:0], packet count[3:0]}
  localparam logic [16:0] VEC [0:6] = '{
    {2'b01, 4'b0000, 7'b0000001, 4'd1},
    {2'b10, 4'b0000, 7'b0000010, 4'd1},
    {2'b11, 4'b1111, 7'b0000001, 4'd6},
    {2'b00, 4'b0100, 7'b0010000, 4'd1},
    {2'b00, 4'b1010, 7'b0001000, 4'd2},
    {2'b10, 4'b0001, 7'b0000010, 4'd2},
    {2'b00, 4'b1000, 7'b0100000, 4'd1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [NES-1:0] src_ready;
  logic [NTB-1:0] tbl_req;
  logic [NS*8-1:0] src_byte;
  logic [CW-1:0] null_cap;
  logic [NS-1:0] src_rd;
  logic [7:0] pkt_byte;
  logic pkt_start, busy;
  logic [NS:0] pid_flag;

  always #2.5 clk = ~clk;

  ts_pkt_sched #(
    .NUM_ES(NES), .NUM_TBL(NTB), .PKT_BYTES(PKT), .SLOT_GAP(G),
    .WINDOW_SLOTS(W), .CAP_W(CW), .SRC_PID(PIDS)
  ) i_ts_pkt_sched (
    .clk(clk), .rst_n(rst_n), .src_ready(src_ready), .tbl_req(tbl_req),
    .src_byte(src_byte), .null_cap(null_cap), .src_rd(src_rd),
    .pkt_byte(pkt_byte), .pkt_start(pkt_start), .busy(busy),
    .pid_flag(pid_flag)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sb(input int s, input int i);
    return 8'((s * 29 + i * 7 + 3) & 255);
  endfunction

  function automatic logic [7:0] exp_byte(input logic [NS:0] f, input int i);
    int s;
    if (f[NS]) begin
      if (i == 0) return 8'h47;
      if (i == 1) return 8'h1F;
      if (i == 2) return 8'hFF;
      if (i == 3) return 8'h10;
      return 8'hFF;
    end
    s = 0;
    for (int k = 0; k < NS; k++) if (f[k]) s = k;
    if (i == 0) return 8'h47;
    if (i == 1) return {sb(s, 1)[7:5], PIDS[s][12:8]};
    if (i == 2) return PIDS[s][7:0];
    return sb(s, i);
  endfunction

  // Source models: byte counters and stream packet queues
  int rd_cnt [NS];
  int es_pkts [NES];
  int es_served [NES];

  always @(posedge clk) begin
    for (int s = 0; s < NS; s++) begin
      if (!rst_n) rd_cnt[s] <= 0;
      else if (src_rd[s]) rd_cnt[s] <= (rd_cnt[s] == PKT - 1) ? 0 : rd_cnt[s] + 1;
    end
    for (int s = 0; s < NES; s++) begin
      if (!rst_n) es_served[s] <= 0;
      else if (src_rd[s] && rd_cnt[s] == PKT - 1) es_served[s] <= es_served[s] + 1;
    end
  end

  always_comb begin
    for (int s = 0; s < NS; s++) src_byte[s*8 +: 8] = sb(s, rd_cnt[s]);
    for (int s = 0; s < NES; s++) src_ready[s] = (es_pkts[s] != es_served[s]);
  end

  // Output monitor
  int cyc = 0;
  int log_n = 0;
  logic [NS:0] log_flag [0:63];
  int log_time [0:63];
  bit in_pkt = 0;
  bit bad;
  int cur_idx;
  logic [NS:0] cur_flag;
  int bad_act, bad_exp;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      in_pkt = 0;
    end else if (busy) begin
      if (pkt_start) begin
        if (in_pkt) chk(0, "R2 packet cut by new start", cur_idx + 1, PKT);
        in_pkt = 1; cur_idx = 0; cur_flag = pid_flag; bad = 0;
        log_flag[log_n % 64] = pid_flag;
        log_time[log_n % 64] = cyc;
        log_n = log_n + 1;
      end else begin
        cur_idx = cur_idx + 1;
        if (!in_pkt && !bad) begin bad = 1; bad_act = 1; bad_exp = 0; end
      end
      if (!bad && pkt_byte != exp_byte(cur_flag, cur_idx)) begin
        bad = 1; bad_act = int'(pkt_byte); bad_exp = int'(exp_byte(cur_flag, cur_idx));
      end
      if (!bad && (pid_flag != cur_flag || src_rd != cur_flag[NS-1:0])) begin
        bad = 1; bad_act = int'(pid_flag); bad_exp = int'(cur_flag);
      end
      if (cur_idx == PKT - 1)
        chk(!bad, cur_flag[NS] ? "R6 null packet bytes" : "R3 source packet bytes",
            bad_act, bad_exp);
    end else if (in_pkt) begin
      chk(cur_idx == PKT - 1, "R2 packet length", cur_idx + 1, PKT);
      in_pkt = 0;
    end
  end

  function automatic int delta_at(input int k);
    return log_time[k % 64] - log_time[(k - 1) % 64];
  endfunction

  task automatic wait_quiet();
    int idle = 0;
    while (idle < 4 * (G + 1) + 2) begin
      @(negedge clk);
      idle = busy ? 0 : idle + 1;
    end
  endtask

  task automatic wait_log(input int n);
    while (log_n < n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      chk(0, "watchdog expired", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    logic [16:0] v;
    bit ok;
    for (int s = 0; s < NES; s++) es_pkts[s] = 0;
    rst_n = 0; tbl_req = '0; null_cap = '0;
    repeat (4) @(negedge clk);
    chk(!busy && !pkt_start && src_rd == '0 && pid_flag == '0, "R1 outputs in reset",
        int'({busy, pkt_start, src_rd, pid_flag}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !pkt_start && src_rd == '0 && pid_flag == '0, "R1 outputs after release",
        int'({busy, pkt_start, src_rd, pid_flag}), 0);

    // R7: zero cap, nothing pending -> nothing at all
    base = log_n;
    repeat (300) @(negedge clk);
    chk(log_n == base, "R7 no null with zero cap", log_n - base, 0);

    // R4 / R5 priority vectors
    for (int t = 0; t < 7; t++) begin
      v = VEC[t];
      base = log_n;
      for (int s = 0; s < NES; s++) es_pkts[s] = es_pkts[s] + int'(v[15 + s]);
      tbl_req = v[14:11];
      @(negedge clk);
      tbl_req = '0;
      wait_quiet();
      chk(log_n - base == int'(v[3:0]), (v[16:15] != 0) ? "R4 packet count" : "R5 served once",
          log_n - base, int'(v[3:0]));
      chk(log_flag[base % 64] == v[10:4], (v[16:15] != 0) ? "R4 first grant" : "R5 first grant",
          int'(log_flag[base % 64]), int'(v[10:4]));
      ok = 1;
      for (int k = base + 1; k < log_n; k++)
        if (log_flag[k % 64] <= log_flag[(k - 1) % 64]) ok = 0;
      chk(ok, "R4 lower index first", t, 0);
    end

    // R5: strobes during a packet and while pending merge into one service
    base = log_n;
    es_pkts[1] = es_pkts[1] + 1;
    wait_log(base + 1);
    repeat (40) @(negedge clk);
    tbl_req = 4'b0001; @(negedge clk); tbl_req = '0;
    repeat (10) @(negedge clk);
    tbl_req = 4'b0001; @(negedge clk); tbl_req = '0;
    wait_quiet();
    chk(log_n - base == 2, "R5 strobe kept during packet, served once", log_n - base, 2);
    chk(log_flag[(base + 1) % 64] == 7'b0000100, "R5 table after stream",
        int'(log_flag[(base + 1) % 64]), 4);

    // R6 / R8: unlimited nulls run back to back
    null_cap = 3'd7;
    base = log_n;
    wait_log(base + 4);
    ok = 1;
    for (int k = base + 1; k < base + 4; k++)
      if (delta_at(k) != S_DELTA || !log_flag[k % 64][NS]) ok = 0;
    chk(ok, "R8 start spacing of back-to-back packets", delta_at(base + 3), S_DELTA);
    chk(log_flag[base % 64] == 7'b1000000, "R6 null flag", int'(log_flag[base % 64]), 64);

    // R9: stream request arriving mid-packet waits for the boundary
    base = log_n;
    wait_log(base + 1);
    repeat (20) @(negedge clk);
    es_pkts[0] = es_pkts[0] + 1;
    wait_log(base + 3);
    chk(log_flag[(base + 1) % 64] == 7'b0000001, "R4 stream after null",
        int'(log_flag[(base + 1) % 64]), 1);
    chk(delta_at(base + 1) == S_DELTA, "R9 no preemption", delta_at(base + 1), S_DELTA);
    chk(log_flag[(base + 2) % 64] == 7'b1000000, "R6 null resumes",
        int'(log_flag[(base + 2) % 64]), 64);

    // R7: cap of 2 per window of 4 slots
    null_cap = 3'd0;
    wait_quiet();
    null_cap = 3'd2;
    base = log_n;
    wait_log(base + 9);
    ok = 1;
    for (int k = base + 4; k < base + 9; k++) begin
      if (delta_at(k) != S_DELTA && delta_at(k) != S_DELTA + 2 * (G + 1)) ok = 0;
      if (delta_at(k) == delta_at(k - 1)) ok = 0;
    end
    chk(ok, "R7 two nulls per window", delta_at(base + 8), S_DELTA + 2 * (G + 1));

    // R7: cap of 1 per window
    null_cap = 3'd1;
    base = log_n;
    wait_log(base + 5);
    ok = 1;
    for (int k = base + 2; k < base + 5; k++)
      if (delta_at(k) != S_DELTA + 3 * (G + 1)) ok = 0;
    chk(ok, "R7 one null per window", delta_at(base + 4), S_DELTA + 3 * (G + 1));

    null_cap = 3'd0;
    wait_quiet();
    chk(!busy && pid_flag == '0, "R10 flag zero when idle", int'(pid_flag), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule